// File: doc/BRIEF.md
# Sequential Multiply and Divide Unit

This unit performs unsigned 16-bit multiplication and unsigned 32-by-16 division on a register pair. The upper half of a 32-bit value is held in Y and the lower half in A. A one-cycle start pulse latches the operation select, the current A and Y values and a 16-bit source operand. The unit then iterates for a fixed number of cycles and returns the new A and Y values with a one-cycle done pulse.

Multiply uses one shift-add step per multiplier bit. Its result also drives a carry/overflow update, and a strobe marks that update so the surrounding core can write its flag register. Divide uses one restoring step per dividend bit and leaves the flags alone. A zero divisor skips the iteration. It raises error and break indications so the core can halt, and the register pair comes back unchanged.

Top module: `muldiv_unit`

## Requirements
- R1: With op = 0 (multiply), the 32-bit product A × source is returned with its upper 16 bits on y_out and its lower 16 bits on a_out.
- R2: On multiply completion, flag_wr pulses together with done, and carry_out and ovf_out are both 1 if the upper product half is nonzero and both 0 otherwise.
- R3: With op = 1 (divide) and a nonzero source, the unsigned 32-bit dividend {Y, A} is divided by the source. a_out receives the low 16 bits of the quotient, truncating quotients that do not fit, and y_out receives the remainder.
- R4: Divide completion does not pulse flag_wr, and it leaves carry_out and ovf_out at their previous values.
- R5: A divide with source 0 completes one cycle after the start edge with err_out = 1 and brk_out = 1, and a_out and y_out equal the A and Y values latched at start.
- R6: done is high for exactly one cycle. It rises 17 clock edges after the start edge for multiply and 33 for divide with a nonzero divisor.
- R7: busy is high from the edge that accepts a start until done rises. A start while busy is ignored and changes neither the result nor the timing of the running operation.
- R8: After reset, done, busy, flag_wr, err_out, brk_out, carry_out, ovf_out, a_out and y_out are all 0.
- R9: err_out and brk_out hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when not busy |
| op | input | 1 | 0 = multiply, 1 = divide |
| a_in | input | 16 | Current A (low half) |
| y_in | input | 16 | Current Y (high half) |
| src_in | input | 16 | Source operand: multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| a_out | output | 16 | New A value |
| y_out | output | 16 | New Y value |
| flag_wr | output | 1 | Carry/overflow update strobe (multiply only) |
| carry_out | output | 1 | Carry flag value |
| ovf_out | output | 1 | Overflow flag value |
| err_out | output | 1 | Divide-by-zero error |
| brk_out | output | 1 | Break request |

## Verification
An iteration counter that is off by one surfaces at the next done. The pulse comes a cycle early or late, and the product or quotient shows up shifted by one bit position. A corrupted partial remainder shows as a wrong quotient bit and remainder at done. The checks cover quotients that overflow 16 bits, all-ones operands and zero results. A stale busy or pending-error state shows as a start that is wrongly ignored or accepted. It also shows as error indications that linger past the next accepted start, and that is visible one cycle after that start.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } md_op_e;
endpackage

// File: rtl/mul_core.sv
module mul_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  hi, lo, mc;
  logic [CW-1:0] cnt;
  logic          done_r;
  logic [W:0]    sum;

  // add multiplicand into upper half when current multiplier bit is set
  always_comb sum = {1'b0, hi} + (lo[0] ? {1'b0, mc} : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi     <= '0;
      lo     <= '0;
      mc     <= '0;
      cnt    <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (go) begin
        hi  <= '0;
        lo  <= mplier;
        mc  <= mcand;
        cnt <= CW'(W);
      end else if (cnt != '0) begin
        hi  <= sum[W:1];
        lo  <= {sum[0], lo[W-1:1]};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) done_r <= 1'b1;
      end
    end
  end

  assign done_o = done_r;
  assign hi_o   = hi;
  assign lo_o   = lo;

  // R6: iteration count is exhausted whenever completion is signalled
  p_mul_cnt_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done_r |-> (cnt == '0));
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           done_o,
  output logic [W-1:0]   quo_o,
  output logic [W-1:0]   rem_o
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW + 1);

  logic [W-1:0]  rem, dv;
  logic [DW-1:0] q;
  logic [CW-1:0] cnt;
  logic          done_r;
  logic [W:0]    shifted, diff;
  logic          fits;

  // restoring step: bring down next dividend bit, trial-subtract divisor
  always_comb begin
    shifted = {rem, q[DW-1]};
    diff    = shifted - {1'b0, dv};
    fits    = (shifted >= {1'b0, dv});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem    <= '0;
      dv     <= '0;
      q      <= '0;
      cnt    <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (go) begin
        rem <= '0;
        q   <= dividend;
        dv  <= divisor;
        cnt <= CW'(DW);
      end else if (cnt != '0) begin
        rem <= fits ? diff[W-1:0] : shifted[W-1:0];
        q   <= {q[DW-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) done_r <= 1'b1;
      end
    end
  end

  assign done_o = done_r;
  assign quo_o  = q[W-1:0];
  assign rem_o  = rem;

  // R3: a finished division leaves a remainder below the divisor
  p_rem_below_div_r3: assert property (@(posedge clk) disable iff (rst)
    done_r |-> (rem < dv));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] src_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] a_out,
  output logic [W-1:0] y_out,
  output logic         flag_wr,
  output logic         carry_out,
  output logic         ovf_out,
  output logic         err_out,
  output logic         brk_out
);
  import muldiv_pkg::*;

  logic         accept, is_div, zero_src;
  logic         mul_go, div_go;
  logic         mul_done, div_done;
  logic [W-1:0] mul_hi, mul_lo, quo, rem;
  logic         dz_pend;
  logic [W-1:0] a_l, y_l;

  always_comb begin
    accept   = start && !busy;
    is_div   = (op == OP_DIV);
    zero_src = (src_in == '0);
    mul_go   = accept && !is_div;
    div_go   = accept && is_div && !zero_src;
  end

  mul_core #(.W(W)) u_mul (
    .clk    (clk),
    .rst    (rst),
    .go     (mul_go),
    .mcand  (a_in),
    .mplier (src_in),
    .done_o (mul_done),
    .hi_o   (mul_hi),
    .lo_o   (mul_lo)
  );

  div_core #(.W(W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (div_go),
    .dividend ({y_in, a_in}),
    .divisor  (src_in),
    .done_o   (div_done),
    .quo_o    (quo),
    .rem_o    (rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      a_out     <= '0;
      y_out     <= '0;
      flag_wr   <= 1'b0;
      carry_out <= 1'b0;
      ovf_out   <= 1'b0;
      err_out   <= 1'b0;
      brk_out   <= 1'b0;
      dz_pend   <= 1'b0;
      a_l       <= '0;
      y_l       <= '0;
    end else begin
      done    <= 1'b0;
      flag_wr <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        a_l     <= a_in;
        y_l     <= y_in;
        err_out <= 1'b0;
        brk_out <= 1'b0;
        dz_pend <= is_div && zero_src;
      end
      if (dz_pend) begin
        dz_pend <= 1'b0;
        busy    <= 1'b0;
        done    <= 1'b1;
        err_out <= 1'b1;
        brk_out <= 1'b1;
        a_out   <= a_l;
        y_out   <= y_l;
      end
      if (mul_done) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        flag_wr   <= 1'b1;
        a_out     <= mul_lo;
        y_out     <= mul_hi;
        carry_out <= (mul_hi != '0);
        ovf_out   <= (mul_hi != '0);
      end
      if (div_done) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        a_out <= quo;
        y_out <= rem;
      end
    end
  end

  // R6: completion is a single-cycle pulse
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: an accepted start makes the unit busy on the next cycle
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R2: flag strobe only with completion, flags agree with the high half
  p_flag_wr_done_r2: assert property (@(posedge clk) disable iff (rst)
    flag_wr |-> done);
  p_mul_flags_r2: assert property (@(posedge clk) disable iff (rst)
    flag_wr |-> ((carry_out == (y_out != '0)) && (ovf_out == carry_out)));

  // R4: a completion without flag strobe leaves the flags untouched
  p_div_keeps_flags_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !flag_wr) |-> ($stable(carry_out) && $stable(ovf_out)));

  // R5: an error always comes with a break request
  p_err_brk_r5: assert property (@(posedge clk) disable iff (rst)
    err_out |-> brk_out);
endmodule

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        start, op;
  logic [15:0] a_in, y_in, src_in;
  logic        busy, done, flag_wr, carry_out, ovf_out, err_out, brk_out;
  logic [15:0] a_out, y_out;

  int n_chk = 0;
  int n_fail = 0;
  int lat;
  logic busy_seen;
  logic prev_c;

  always #2 clk = ~clk;

  muldiv_unit dut (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .a_in(a_in), .y_in(y_in), .src_in(src_in),
    .busy(busy), .done(done), .a_out(a_out), .y_out(y_out),
    .flag_wr(flag_wr), .carry_out(carry_out), .ovf_out(ovf_out),
    .err_out(err_out), .brk_out(brk_out)
  );

  // fields: op | a | y | src | exp_a | exp_y | exp_carry
  localparam logic [81:0] VEC [0:8] = '{
    {1'b0, 16'h0003, 16'h0000, 16'h0005, 16'h000F, 16'h0000, 1'b0},
    {1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0001, 16'hFFFE, 1'b1},
    {1'b1, 16'h0064, 16'h0000, 16'h0007, 16'h000E, 16'h0002, 1'b0},
    {1'b0, 16'h1000, 16'h0000, 16'h0010, 16'h0000, 16'h0001, 1'b1},
    {1'b1, 16'h0000, 16'h0001, 16'h0003, 16'h5555, 16'h0001, 1'b0},
    {1'b0, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0},
    {1'b1, 16'h0000, 16'h0002, 16'h0001, 16'h0000, 16'h0000, 1'b0},
    {1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0001, 16'h0000, 1'b0},
    {1'b1, 16'h0005, 16'h0000, 16'h0009, 16'h0000, 16'h0005, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic opv, input logic [15:0] av, yv, sv);
    @(negedge clk);
    op = opv; a_in = av; y_in = yv; src_in = sv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_seen = busy;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; op = 1'b0;
    a_in = '0; y_in = '0; src_in = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!done && !busy && !flag_wr && !err_out && !brk_out && !carry_out && !ovf_out,
        "R8", "control outputs", {done, busy, flag_wr, err_out, brk_out, carry_out, ovf_out}, 0);
    chk(a_out == 0 && y_out == 0, "R8", "data outputs", {a_out, y_out}, 0);
    rst = 1'b0;
    prev_c = 1'b0;

    // table walk: R1, R2, R3, R4, R6, R7
    for (int i = 0; i < 9; i++) begin
      logic [81:0] v;
      v = VEC[i];
      run_op(v[81], v[80:65], v[64:49], v[48:33]);
      chk(busy_seen, "R7", "busy after start", busy_seen, 1);
      chk(a_out == v[32:17], v[81] ? "R3" : "R1", "a_out", a_out, v[32:17]);
      chk(y_out == v[16:1], v[81] ? "R3" : "R1", "y_out", y_out, v[16:1]);
      chk(lat == (v[81] ? 33 : 17), "R6", "latency", lat, v[81] ? 33 : 17);
      if (!v[81]) begin
        chk(flag_wr && carry_out == v[0] && ovf_out == v[0], "R2", "mul flags",
            {flag_wr, carry_out, ovf_out}, {1'b1, v[0], v[0]});
        prev_c = v[0];
      end else begin
        chk(!flag_wr && carry_out == prev_c && ovf_out == prev_c, "R4", "div flags",
            {flag_wr, carry_out, ovf_out}, {1'b0, prev_c, prev_c});
      end
      chk(!err_out, "R9", "no error on normal op", err_out, 0);
      @(negedge clk);
      chk(!done, "R6", "done single cycle", done, 0);
    end

    // R5: divide by zero, prev carry currently 0
    run_op(1'b1, 16'hBEEF, 16'h1357, 16'h0000);
    chk(lat == 1, "R5", "dz latency", lat, 1);
    chk(err_out && brk_out, "R5", "err/brk", {err_out, brk_out}, 2'b11);
    chk(a_out == 16'hBEEF && y_out == 16'h1357, "R5", "pair kept", {a_out, y_out}, 32'h1357BEEF);
    chk(!flag_wr, "R5", "no flag write", flag_wr, 0);
    repeat (3) @(negedge clk);
    chk(err_out && brk_out, "R9", "err held", {err_out, brk_out}, 2'b11);

    // R9 cleared on accepted start; R7 start while busy ignored
    @(negedge clk);
    op = 1'b0; a_in = 16'h0007; y_in = '0; src_in = 16'h0009; start = 1'b1;
    @(negedge clk);
    chk(!err_out && !brk_out, "R9", "err cleared", {err_out, brk_out}, 0);
    op = 1'b1; a_in = 16'h0100; y_in = 16'h0000; src_in = 16'h0002;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 17, "R7", "busy start left timing", lat, 17);
    chk(a_out == 16'h003F && y_out == 16'h0000, "R7", "busy start ignored",
        {y_out, a_out}, 32'h0000003F);
    begin
      int extra = 0;
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk(extra == 0, "R7", "no extra done", extra, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule